// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the byte-level control core of a two-wire (I2C) serial EEPROM slave that uses two-byte word addresses. A front end that is not part of this block detects start and stop conditions, filters glitches, and delivers the sampled SDA value along with single-cycle strobes for the rising and falling SCL edges. The engine shifts bits in and out and decodes the device-select byte against a fixed 4-bit identifier and three strap inputs. It loads the word pointer from the two address bytes. On a write, each accepted data byte goes to a page-buffer port. On a read, bytes are taken from the array read port, which responds combinationally.

The engine pulls SDA low through an open-drain enable, both to acknowledge received bytes and to drive read data. When a stop follows accepted write data, the engine pulses a commit to the separate write-cycle block. That block returns a busy flag. While busy is set, the engine does not acknowledge its own address, so a master can poll. A write-protect input lets the address phase complete but refuses data. The word pointer persists between transactions. For reads it advances across the whole array and wraps to 0. For writes it advances only within the current page.

Top module: `eeprom_slave_engine`

## Requirements
- R1: The select byte is taken MSB first: bits 7:4 must equal 4'b1010, bits 3:1 must equal strap_i[2:0], and bit 0 selects a read (1) or a write (0). On a match with busy_i low, sda_oe_o is 1 for the whole ninth SCL clock.
- R2: On a select byte that does not match, there is no ACK, and sda_oe_o stays 0 until the next start, whatever the master clocks.
- R3: While busy_i is high, a select byte that otherwise matches gets no ACK.
- R4: After a write select, the next two bytes are acknowledged and load the pointer. The pointer's upper ADDR_W-8 bits come from the low bits of the first byte, the remaining bits of that byte are ignored, and the low 8 bits come from the second byte.
- R5: With wp_i low, each further write byte is acknowledged and appears once on pg_we_o/pg_addr_o/pg_data_o at the current pointer. After each byte, only the low PAGE_W bits of the pointer increment, wrapping inside the page.
- R6: A stop at a frame boundary (after the ninth clock), when at least one data byte was accepted since the start, gives a single one-cycle commit_o pulse. Any other stop gives no commit_o.
- R7: With wp_i high, the select and both address bytes are acknowledged. The first data byte is not acknowledged and produces no pg_we_o, and the following stop produces no commit_o.
- R8: In a read, eight bits of rd_data_i at the pointer are driven MSB first (sda_oe_o = inverted bit), and SDA is released in the ninth clock. If the master ACKs, the next byte follows. After a NACK, SDA stays released until a start or stop.
- R9: A read with no address phase starts at the address one above the last byte read or written. Out of reset the pointer is 0.
- R10: A write select, two address bytes and then a repeated start with a read select return data from the newly loaded address.
- R11: During reads the pointer increments across the full 2^ADDR_W array and wraps from the top address to 0.
- R12: A start or stop in the middle of a byte abandons the transaction and drops the partial byte. If data bytes were pending, pg_drop_o pulses instead of commit_o, and the next select byte decodes normally.
- R13: sda_oe_o is 0 after reset and changes only on an SCL falling strobe or on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start (or repeated start) detected, one cycle |
| stop_i | input | 1 | Stop detected, one cycle |
| scl_rise_i | input | 1 | SCL rising-edge strobe; sda_i is sampled on it |
| scl_fall_i | input | 1 | SCL falling-edge strobe; SDA output may change on it |
| sda_i | input | 1 | Filtered SDA level |
| strap_i | input | 3 | Device address strap pins |
| wp_i | input | 1 | Write protect, high blocks writes |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Open-drain SDA pull-down enable |
| rd_addr_o | output | ADDR_W | Word pointer, array read address |
| rd_data_i | input | 8 | Array read data for rd_addr_o |
| pg_we_o | output | 1 | Page buffer byte write strobe |
| pg_addr_o | output | ADDR_W | Page buffer byte address |
| pg_data_o | output | 8 | Page buffer byte data |
| commit_o | output | 1 | Start the programming cycle |
| pg_drop_o | output | 1 | Discard pending page buffer bytes |

## Verification
The embedded properties check several rules on every cycle. SDA stays released while the engine is idle or holding off. The output enable changes only on a falling strobe or a bus condition. Writes never occur under protection, and a commit always follows a stop. The pointer's page-limited and full-array increments are checked as well. Other behaviour only the bench's scenarios can show, by comparing data end to end against its own memory model. This covers which address a current read continues from, the polling handshake across a programming cycle, discarding on an aborted write, and the returned data after a random read or a wrap.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_HOLD
  } slv_state_e;
endpackage

// File: rtl/eeprom_slv_bitio.sv
module eeprom_slv_bitio
  import eeprom_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              tx_mode_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              ack_drive_i,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              ack_stb_o,
  output logic              ack_sda_o,
  output logic              frame_idle_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      sda_oe_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (cnt_q == ACK_SLOT) cnt_q <= '0;
        else begin
          sh_q  <= rx_byte_o;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (scl_fall_i) begin
        // ack slot: receiver drives, transmitter releases
        if (cnt_q == ACK_SLOT) sda_oe_o <= tx_mode_i ? 1'b0 : ack_drive_i;
        else sda_oe_o <= tx_mode_i ? ~tx_byte_i[3'd7 - cnt_q[2:0]] : 1'b0;
      end
    end
  end

  assign rx_byte_o    = {sh_q[BYTE_W-2:0], sda_i};
  assign byte_stb_o   = scl_rise_i && !restart_i && (cnt_q == LAST_DATA);
  assign ack_stb_o    = scl_rise_i && !restart_i && (cnt_q == ACK_SLOT);
  assign ack_sda_o    = sda_i;
  assign frame_idle_o = (cnt_q == '0);

  assert_oe_on_fall_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !restart_i) |=> $stable(sda_oe_o));
endmodule

// File: rtl/eeprom_slv_ptr.sv
module eeprom_slv_ptr #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_full_i,
  input  logic              inc_page_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_full_i) ptr_q <= ptr_q + ADDR_W'(1);
    else if (inc_page_i) ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + PAGE_W'(1);
  end

  assign ptr_o = ptr_q;

  assert_page_keeps_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !load_i && !inc_full_i) |=>
      (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

  assert_read_wraps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_full_i && !load_i && (ptr_q == '1)) |=> (ptr_q == '0));
endmodule

// File: rtl/eeprom_slave_engine.sv
module eeprom_slave_engine
  import eeprom_slv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              pg_we_o,
  output logic [ADDR_W-1:0] pg_addr_o,
  output logic [BYTE_W-1:0] pg_data_o,
  output logic              commit_o,
  output logic              pg_drop_o
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  slv_state_e        state_q;
  logic              tx_mode_q, ack_q, wr_pend_q;
  logic [HI_W-1:0]   addr_hi_q;
  logic              restart, byte_stb, ack_stb, ack_sda, frame_idle;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] ptr;
  logic              sel_match, ld_ptr, inc_full, inc_page;

  assign restart   = start_i | stop_i;
  assign sel_match = (rx_byte[7:4] == DEV_ID) && (rx_byte[3:1] == strap_i) && !busy_i;
  assign ld_ptr    = byte_stb && (state_q == ST_ALO);
  assign inc_full  = byte_stb && (state_q == ST_RDAT);
  assign inc_page  = byte_stb && (state_q == ST_WDAT) && !wp_i;

  eeprom_slv_bitio u_bitio (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .scl_rise_i   (scl_rise_i),
    .scl_fall_i   (scl_fall_i),
    .sda_i        (sda_i),
    .tx_mode_i    (tx_mode_q),
    .tx_byte_i    (rd_data_i),
    .ack_drive_i  (ack_q),
    .byte_stb_o   (byte_stb),
    .rx_byte_o    (rx_byte),
    .ack_stb_o    (ack_stb),
    .ack_sda_o    (ack_sda),
    .frame_idle_o (frame_idle),
    .sda_oe_o     (sda_oe_o)
  );

  eeprom_slv_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_ptr),
    .load_val_i ({addr_hi_q, rx_byte}),
    .inc_full_i (inc_full),
    .inc_page_i (inc_page),
    .ptr_o      (ptr)
  );

  assign rd_addr_o = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_mode_q <= 1'b0;
      ack_q     <= 1'b0;
      wr_pend_q <= 1'b0;
      addr_hi_q <= '0;
      pg_we_o   <= 1'b0;
      pg_addr_o <= '0;
      pg_data_o <= '0;
      commit_o  <= 1'b0;
      pg_drop_o <= 1'b0;
    end else begin
      pg_we_o   <= 1'b0;
      commit_o  <= 1'b0;
      pg_drop_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_SEL;
        tx_mode_q <= 1'b0;
        ack_q     <= 1'b0;
        wr_pend_q <= 1'b0;
        pg_drop_o <= wr_pend_q;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        tx_mode_q <= 1'b0;
        ack_q     <= 1'b0;
        wr_pend_q <= 1'b0;
        commit_o  <= wr_pend_q & frame_idle;
        pg_drop_o <= wr_pend_q & ~frame_idle;
      end else if (byte_stb) begin
        case (state_q)
          ST_SEL: begin
            if (sel_match) begin
              ack_q   <= 1'b1;
              state_q <= rx_byte[0] ? ST_RDAT : ST_AHI;
            end else state_q <= ST_HOLD;
          end
          ST_AHI: begin
            ack_q     <= 1'b1;
            addr_hi_q <= rx_byte[HI_W-1:0];
            state_q   <= ST_ALO;
          end
          ST_ALO: begin
            ack_q   <= 1'b1;
            state_q <= ST_WDAT;
          end
          ST_WDAT: begin
            if (wp_i) state_q <= ST_HOLD;
            else begin
              ack_q     <= 1'b1;
              pg_we_o   <= 1'b1;
              pg_addr_o <= ptr;
              pg_data_o <= rx_byte;
              wr_pend_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (ack_stb) begin
        ack_q <= 1'b0;
        if (tx_mode_q) begin
          // master NACK ends the read
          if (ack_sda) begin
            state_q   <= ST_HOLD;
            tx_mode_q <= 1'b0;
          end
        end else tx_mode_q <= (state_q == ST_RDAT);
      end
    end
  end

  assert_released_when_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) || (state_q == ST_HOLD)) |-> !sda_oe_o);

  assert_busy_no_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb && (state_q == ST_SEL) && busy_i) |=> (state_q == ST_HOLD));

  assert_commit_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i));

  assert_wp_blocks_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |-> !$past(wp_i));

  assert_one_outcome_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_o, pg_drop_o, pg_we_o}));
endmodule

// File: tb/eeprom_slave_engine_bench.sv
module eeprom_slave_engine_bench;
  localparam int AW = 13;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_s = 0, stop_s = 0, rise = 0, fall = 0, m_sda = 1, wp = 0, busy = 0;
  logic sda, sda_oe, pg_we, commit, drop;
  logic [AW-1:0] rd_addr, pg_addr;
  logic [7:0] rd_data, pg_data;

  logic [7:0] act_mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [AW-1:0] pq_a [64];
  logic [7:0] pq_d [64];
  int pq_n = 0, busy_cnt = 0;
  logic [AW-1:0] last_pg_addr = '0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] eptr;

  always #10 clk = ~clk;

  assign sda = m_sda & ~sda_oe;
  assign rd_data = act_mem[rd_addr];

  eeprom_slave_engine u_eeprom_slave_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s), .stop_i(stop_s),
    .scl_rise_i(rise), .scl_fall_i(fall), .sda_i(sda), .strap_i(STRAP),
    .wp_i(wp), .busy_i(busy), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .pg_we_o(pg_we), .pg_addr_o(pg_addr),
    .pg_data_o(pg_data), .commit_o(commit), .pg_drop_o(drop));

  // page buffer and write-cycle model
  always @(negedge clk) begin
    if (pg_we) begin
      if (pq_n < 64) begin pq_a[pq_n] = pg_addr; pq_d[pq_n] = pg_data; pq_n++; end
      last_pg_addr = pg_addr;
    end
    if (commit) begin
      for (int k = 0; k < pq_n; k++) act_mem[pq_a[k]] = pq_d[k];
      pq_n = 0;
      busy_cnt = 120;
    end else if (busy_cnt != 0) busy_cnt--;
    if (drop) pq_n = 0;
    busy = (busy_cnt != 0);
  end

  function automatic logic [AW-1:0] page_next(logic [AW-1:0] a);
    return {a[AW-1:5], a[4:0] + 5'd1};
  endfunction
  function automatic logic [AW-1:0] full_next(logic [AW-1:0] a);
    return a + 13'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic bit_x(input logic m, output logic seen);
    m_sda = m; tick(); tick();
    seen = sda;
    rise = 1; tick(); rise = 0; tick();
    fall = 1; tick(); fall = 0;
  endtask

  task automatic do_start();
    m_sda = 1; start_s = 1; tick(); start_s = 0; tick();
  endtask

  task automatic do_stop(output logic c, output logic d);
    stop_s = 1; tick(); stop_s = 0; c = commit; d = drop; tick();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    acked = !s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); b[i] = s; end
    bit_x(!mack, s);
  endtask

  task automatic sel(input logic rw, output logic acked);
    wr_byte({4'b1010, STRAP, rw}, acked);
  endtask

  task automatic poll(output int nacks);
    logic a, c, d;
    nacks = 0;
    for (int k = 0; k < 60; k++) begin
      do_start(); sel(1'b0, a); do_stop(c, d);
      if (a) break;
      nacks++;
    end
  endtask

  task automatic set_addr(input logic [AW-1:0] a, input logic [2:0] junk, input string req);
    logic k;
    do_start(); sel(1'b0, k);
    chk(k, req, k, 1);
    wr_byte({junk, a[12:8]}, k); chk(k, req, k, 1);
    wr_byte(a[7:0], k); chk(k, req, k, 1);
    eptr = a;
  endtask

  task automatic read_n(input int n, input string req);
    logic [7:0] b; logic a;
    do_start(); sel(1'b1, a); chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      chk(b == exp_mem[eptr], req, b, exp_mem[eptr]);
      eptr = full_next(eptr);
    end
  endtask

  task automatic write_n(input logic [AW-1:0] a, input int n, input string req);
    logic k, c, d; logic [7:0] v; int nk;
    set_addr(a, 3'($urandom), "R4");
    for (int i = 0; i < n; i++) begin
      v = 8'($urandom);
      wr_byte(v, k);
      chk(k, req, k, 1);
      chk(last_pg_addr == eptr, req, last_pg_addr, eptr);
      exp_mem[eptr] = v;
      eptr = page_next(eptr);
    end
    do_stop(c, d);
    chk(c && !d, "R6", c, 1);
    poll(nk);
    chk(nk >= 1, "R3", nk, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1: actual cycles 200000 expected fewer");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, c, d, s; logic [7:0] b; logic [AW-1:0] x; int nk;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      act_mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
      exp_mem[i] = act_mem[i];
    end
    repeat (3) tick();
    rst_n = 1; tick();
    chk(sda_oe == 0, "R13", sda_oe, 0);
    chk(rd_addr == 0, "R9", rd_addr, 0);
    eptr = '0;

    // wrong strap, then master clocks ones: bus must stay released
    do_start(); wr_byte({4'b1010, ~STRAP, 1'b1}, a);
    chk(!a, "R2", a, 0);
    rd_byte(1'b0, b);
    chk(b == 8'hFF && sda_oe == 0, "R2", b, 8'hFF);
    do_stop(c, d);
    // wrong identifier
    do_start(); wr_byte({4'b1011, STRAP, 1'b0}, a);
    chk(!a, "R1", a, 0);
    do_stop(c, d);
    // current read from reset pointer
    read_n(2, "R9"); do_stop(c, d);

    // byte write near top; junk bits in high byte
    write_n(13'h1FFE, 1, "R5");
    chk(act_mem[13'h1FFE] == exp_mem[13'h1FFE], "R4", act_mem[13'h1FFE], exp_mem[13'h1FFE]);
    read_n(2, "R11"); do_stop(c, d);
    chk(eptr == 13'h0001, "R11", eptr, 1);

    // page wrap: 3E,3F,20,21
    write_n(13'h003E, 4, "R5");
    chk(act_mem[13'h0020] == exp_mem[13'h0020], "R5", act_mem[13'h0020], exp_mem[13'h0020]);
    chk(act_mem[13'h0040] == exp_mem[13'h0040], "R5", act_mem[13'h0040], exp_mem[13'h0040]);

    // write protect
    wp = 1;
    set_addr(13'h0100, 3'b000, "R7");
    wr_byte(8'h5A, a);
    chk(!a, "R7", a, 0);
    do_stop(c, d);
    chk(!c, "R7", c, 0);
    wp = 0;
    set_addr(13'h0100, 3'b000, "R10");
    read_n(1, "R10"); do_stop(c, d);

    // NACK releases the bus
    set_addr(13'h0200, 3'b111, "R10");
    read_n(1, "R8");
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R8", b, 8'hFF);
    do_stop(c, d);

    // mid-byte stop after one accepted byte
    set_addr(13'h0300, 3'b000, "R12");
    wr_byte(8'hC3, a);
    for (int i = 0; i < 4; i++) bit_x(1'b0, s);
    do_stop(c, d);
    chk(!c && d, "R12", {c, d}, 1);
    chk(act_mem[13'h0300] == exp_mem[13'h0300], "R12", act_mem[13'h0300], exp_mem[13'h0300]);
    // mid-byte start then a normal random read
    do_start();
    for (int i = 0; i < 3; i++) bit_x(1'b1, s);
    set_addr(13'h0300, 3'b010, "R12");
    read_n(3, "R12"); do_stop(c, d);

    // random mix
    for (int t = 0; t < 30; t++) begin
      case ($urandom % 3)
        0: write_n(13'($urandom), 1 + int'($urandom % 36), "R5");
        1: begin
          x = 13'($urandom);
          set_addr(x, 3'($urandom), "R10");
          read_n(1 + int'($urandom % 5), "R10"); do_stop(c, d);
        end
        default: begin read_n(1 + int'($urandom % 5), "R9"); do_stop(c, d); end
      endcase
    end
    poll(nk);
    chk(nk == 0, "R3", nk, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule